// File: doc/BRIEF.md
# Microcycle Phase Timing Generator

This block turns a fast oscillator tick into the time states of a processor microcycle. Every tick of `clk` is one time state. The states split into two halves. The phase half has four states, P1 to P4, and the master clock output is high during them. The bar half has four states, B1 to B4, and the master clock is low during them. A plain microinstruction runs P1, P2, B1, B2. Microinstructions that touch the bus or the address translator lengthen the cycle in three ways. P2 repeats while the bus is busy. P3 holds until the slave answers. Extra states are added for the data-in deskew tick, for address relocation and for error recovery.

The generator samples the microinstruction class during P1 and uses it until the next P1. Bus grant, abort and the no-responder flag are read in the tick where they matter. Slave-sync is asynchronous, so it passes through a flop chain before it is used. Each state has a one-hot strobe. The generator also drives three pulses that downstream latches use:
- an address-latch pulse in P3,
- a relocated-address pulse in B3,
- a data-capture pulse in P4.

Top module: `mcyc_timing_gen`

## Requirements
- R1: While reset is asserted, and in the first tick after it is released, `state_oh` is 8'h01 (P1), `mclk` is high and all three pulses are low.
- R2: `state_oh` always has exactly one bit set. Bit k is state k, in the order P1,P2,P3,P4,B1,B2,B3,B4 (bits 0..7). `mclk` is high exactly when one of bits 0..3 is set.
- R3: The class `op_cls` is sampled in P1. The codes are: 0 plain, 1 address, 2 relocated address, 3 data-in, 4 data-out, and 5..7 plain. A plain cycle is P1,P2,B1,B2 and is then followed by P1.
- R4: In a data-in or data-out cycle, P2 repeats while `bus_grant` is low. It moves to P3 at the first edge where `bus_grant` is high.
- R5: In a data cycle, P3 is left only on synchronized slave-sync. If `ssyn_in` first goes high before edge k while in P3, P3 is left at edge k+2 (two-flop chain).
- R6: A data-out cycle goes P3 to B1. A data-in cycle goes P3, then exactly one P4 tick with `din_stb` high, then B1.
- R7: An address cycle is P1,P2,P3,B1,B2. `lat_add` is high during its single P3 tick.
- R8: A relocated-address cycle is P1,P2,P3,B1,B2,B3,B4. `lat_add` is high in P3, and `reloc_stb` is high in B3.
- R9: If `abort_req` is high in any phase state, the next state is B3, then B4, then P1. If `abort_req` is high in B1 or B2, then B2 is followed by B3 and B4.
- R10: If `nx_ctl` is high in B2, the next states are B3 and B4, then P1.
- R11: `abort_req` is ignored in B3 and B4: the sequence B3, B4, P1 is unchanged.
- R12: `lat_add` is high only in P3, `din_stb` only in P4 and `reloc_stb` only in B3. `lat_add` and `din_stb` stay low in a tick where `abort_req` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator tick; one time state per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_cls | input | 3 | Microinstruction class, sampled in P1 |
| bus_grant | input | 1 | Bus is free for the data transfer |
| ssyn_in | input | 1 | Asynchronous slave-sync from the bus |
| abort_req | input | 1 | Abort, time-out, parity or chip-reset request |
| nx_ctl | input | 1 | Jump target control unit did not respond |
| state_oh | output | 8 | One-hot time state, bit 0 = P1 ... bit 7 = B4 |
| mclk | output | 1 | Master clock: high in phase time |
| lat_add | output | 1 | Address latch pulse |
| reloc_stb | output | 1 | Relocated address latch pulse |
| din_stb | output | 1 | Input data capture pulse |

## Verification
The bench sweeps every class code against several grant delays, slave-sync delays and no-responder settings. It then places an abort in every tick of each class, and compares each tick with a sequence built from the rules.

The bench targets these corner cases:
- The grant wait. If the wait is miscounted, P2 runs one tick too many or too few.
- The synchronizer latency. A missing flop would leave P3 one tick early.
- A data-in cycle that skips P4, or a data-out cycle that inserts it.
- An abort in B1. It must be remembered until B2, or the recovery states are lost.
- An abort during B3 or B4. If this is not ignored, the recovery pair repeats or is cut short.
- The pending-relocation flag. If it is not cleared, the next plain cycle gains a spurious B3.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;
  localparam int NST = 8;
  localparam int OPW = 3;

  typedef enum logic [2:0] {
    S_PT1  = 3'd0,
    S_PT2  = 3'd1,
    S_PT3  = 3'd2,
    S_PT4  = 3'd3,
    S_PBT1 = 3'd4,
    S_PBT2 = 3'd5,
    S_PBT3 = 3'd6,
    S_PBT4 = 3'd7
  } tstate_e;

  localparam logic [OPW-1:0] OP_SHORT = 3'd0;
  localparam logic [OPW-1:0] OP_ADDR  = 3'd1;
  localparam logic [OPW-1:0] OP_RELOC = 3'd2;
  localparam logic [OPW-1:0] OP_DIN   = 3'd3;
  localparam logic [OPW-1:0] OP_DOUT  = 3'd4;

  function automatic logic is_addr_op(logic [OPW-1:0] op);
    return (op == OP_ADDR) || (op == OP_RELOC);
  endfunction

  function automatic logic is_data_op(logic [OPW-1:0] op);
    return (op == OP_DIN) || (op == OP_DOUT);
  endfunction

  function automatic logic is_phase(tstate_e s);
    return (s == S_PT1) || (s == S_PT2) || (s == S_PT3) || (s == S_PT4);
  endfunction

  function automatic logic [NST-1:0] to_onehot(tstate_e s);
    logic [NST-1:0] v;
    v = '0;
    v[s] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/mcyc_sync.sv
module mcyc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  generate
    if (STAGES < 2) begin : g_single
      logic r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= 1'b0;
        else        r <= d;
      end
      assign q = r;
    end else begin : g_chain
      logic [STAGES-1:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], d};
      end
      assign q = sh[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/mcyc_next.sv
module mcyc_next
  import mcyc_pkg::*;
(
  input  tstate_e         st,
  input  logic [OPW-1:0]  op,
  input  logic            grant,
  input  logic            ssyn_s,
  input  logic            abort,
  input  logic            nx,
  input  logic            reloc_pend,
  input  logic            err_pend,
  output tstate_e         nxt,
  output logic            set_reloc,
  output logic            set_err
);
  always_comb begin
    nxt       = st;
    set_reloc = 1'b0;
    set_err   = 1'b0;
    case (st)
      S_PT1: nxt = abort ? S_PBT3 : S_PT2;
      S_PT2: begin
        if (abort)               nxt = S_PBT3;
        else if (is_data_op(op)) nxt = grant ? S_PT3 : S_PT2;
        else if (is_addr_op(op)) nxt = S_PT3;
        else                     nxt = S_PBT1;
      end
      S_PT3: begin
        if (abort) nxt = S_PBT3;
        else if (is_data_op(op)) begin
          if (ssyn_s) nxt = (op == OP_DIN) ? S_PT4 : S_PBT1;
          else        nxt = S_PT3;
        end else begin
          nxt       = S_PBT1;
          set_reloc = (op == OP_RELOC);
        end
      end
      S_PT4: nxt = abort ? S_PBT3 : S_PBT1;
      S_PBT1: begin
        nxt     = S_PBT2;
        set_err = abort;
      end
      S_PBT2: nxt = (abort || err_pend || reloc_pend || nx) ? S_PBT3 : S_PT1;
      S_PBT3: nxt = S_PBT4;
      S_PBT4: nxt = S_PT1;
      default: nxt = S_PT1;
    endcase
  end
endmodule

// File: rtl/mcyc_strobe.sv
module mcyc_strobe
  import mcyc_pkg::*;
(
  input  tstate_e         st,
  input  logic [OPW-1:0]  op,
  input  logic            abort,
  input  logic            reloc_pend,
  output logic [NST-1:0]  st_oh,
  output logic            mclk,
  output logic            lat_add,
  output logic            reloc_stb,
  output logic            din_stb
);
  always_comb begin
    st_oh     = to_onehot(st);
    mclk      = is_phase(st);
    lat_add   = (st == S_PT3) && is_addr_op(op) && !abort;
    din_stb   = (st == S_PT4) && !abort;
    reloc_stb = (st == S_PBT3) && reloc_pend;
  end
endmodule

// File: rtl/mcyc_timing_gen.sv
module mcyc_timing_gen
  import mcyc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      op_cls,
  input  logic            bus_grant,
  input  logic            ssyn_in,
  input  logic            abort_req,
  input  logic            nx_ctl,
  output logic [7:0]      state_oh,
  output logic            mclk,
  output logic            lat_add,
  output logic            reloc_stb,
  output logic            din_stb
);
  tstate_e        st_q;
  tstate_e        st_d;
  logic [OPW-1:0] op_q;
  logic           reloc_pend;
  logic           err_pend;
  logic           ssyn_s;
  logic           set_reloc;
  logic           set_err;
  logic           to_pt1;

  mcyc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (ssyn_in),
    .q     (ssyn_s)
  );

  mcyc_next u_next (
    .st         (st_q),
    .op         (op_q),
    .grant      (bus_grant),
    .ssyn_s     (ssyn_s),
    .abort      (abort_req),
    .nx         (nx_ctl),
    .reloc_pend (reloc_pend),
    .err_pend   (err_pend),
    .nxt        (st_d),
    .set_reloc  (set_reloc),
    .set_err    (set_err)
  );

  assign to_pt1 = (st_d == S_PT1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= S_PT1;
      op_q       <= OP_SHORT;
      reloc_pend <= 1'b0;
      err_pend   <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == S_PT1) op_q <= op_cls;
      if (to_pt1)         reloc_pend <= 1'b0;
      else if (set_reloc) reloc_pend <= 1'b1;
      if (to_pt1)         err_pend <= 1'b0;
      else if (set_err)   err_pend <= 1'b1;
    end
  end

  mcyc_strobe u_strobe (
    .st         (st_q),
    .op         (op_q),
    .abort      (abort_req),
    .reloc_pend (reloc_pend),
    .st_oh      (state_oh),
    .mclk       (mclk),
    .lat_add    (lat_add),
    .reloc_stb  (reloc_stb),
    .din_stb    (din_stb)
  );
endmodule

// File: rtl/mcyc_timing_chk.sv
module mcyc_timing_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] state_oh,
  input logic       mclk,
  input logic       lat_add,
  input logic       reloc_stb,
  input logic       din_stb,
  input logic       bus_grant,
  input logic       abort_req,
  input logic       nx_ctl,
  input logic [2:0] op_q
);
  wire in_phase = |state_oh[3:0];
  wire op_data  = (op_q == 3'd3) || (op_q == 3'd4);

  AST_ONE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(state_oh) == 1); // R2
  AST_MCLK_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    mclk == in_phase); // R2
  AST_PT1_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_oh[0] && !abort_req) |=> state_oh[1]); // R3
  AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_oh[1] && op_data && !bus_grant && !abort_req) |=> state_oh[1]); // R4
  AST_PT4_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_oh[3] && !abort_req) |=> state_oh[4]); // R6
  AST_RELOC_PBT3: assert property (@(posedge clk) disable iff (!rst_n)
    reloc_stb |-> state_oh[6]); // R8
  AST_ABORT_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_phase && abort_req) |=> state_oh[6]); // R9
  AST_NX_RECOVER: assert property (@(posedge clk) disable iff (!rst_n)
    (state_oh[5] && nx_ctl) |=> state_oh[6]); // R10
  AST_PBT3_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    state_oh[6] |=> state_oh[7]); // R11
  AST_PBT4_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    state_oh[7] |=> state_oh[0]); // R11
  AST_DIN_PT4: assert property (@(posedge clk) disable iff (!rst_n)
    din_stb |-> state_oh[3]); // R12
  AST_LAT_PT3: assert property (@(posedge clk) disable iff (!rst_n)
    lat_add |-> state_oh[2]); // R12
endmodule

bind mcyc_timing_gen mcyc_timing_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .state_oh  (state_oh),
  .mclk      (mclk),
  .lat_add   (lat_add),
  .reloc_stb (reloc_stb),
  .din_stb   (din_stb),
  .bus_grant (bus_grant),
  .abort_req (abort_req),
  .nx_ctl    (nx_ctl),
  .op_q      (op_q)
);

// File: tb/mcyc_timing_gen_tb.sv
module mcyc_timing_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] op_cls = 3'd0;
  logic       bus_grant = 1'b0;
  logic       ssyn_in = 1'b0;
  logic       abort_req = 1'b0;
  logic       nx_ctl = 1'b0;
  logic [7:0] state_oh;
  logic       mclk;
  logic       lat_add;
  logic       reloc_stb;
  logic       din_stb;

  int checks = 0;
  int failures = 0;
  int ticks = 0;

  mcyc_timing_gen u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_cls    (op_cls),
    .bus_grant (bus_grant),
    .ssyn_in   (ssyn_in),
    .abort_req (abort_req),
    .nx_ctl    (nx_ctl),
    .state_oh  (state_oh),
    .mclk      (mclk),
    .lat_add   (lat_add),
    .reloc_stb (reloc_stb),
    .din_stb   (din_stb)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    ticks <= ticks + 1;
    if (ticks > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog: run did not finish (act=%0d ticks, exp<150000)", ticks);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int decode(logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return -1;
  endfunction

  // state indices: 0..3 phase states, 4..7 bar states
  task automatic run_cycle(input int cls, input int g, input int d, input int ab, input int nx);
    int exp_s[64];
    int n;
    int n_full;
    int pt2c;
    int pt3c;
    int idx;
    bit data_c;
    bit addr_c;
    bit ok_seq;
    data_c = (cls == 3) || (cls == 4);
    addr_c = (cls == 1) || (cls == 2);
    n = 0;
    exp_s[n++] = 0;
    if (data_c) begin
      for (int k = 0; k <= g; k++) exp_s[n++] = 1;
    end else exp_s[n++] = 1;
    if (addr_c) exp_s[n++] = 2;
    if (data_c) for (int k = 0; k < 3 + d; k++) exp_s[n++] = 2;
    if (cls == 3) exp_s[n++] = 3;
    exp_s[n++] = 4;
    exp_s[n++] = 5;
    if (cls == 2 || nx != 0) begin
      exp_s[n++] = 6;
      exp_s[n++] = 7;
    end
    n_full = n;
    if (ab >= 0 && ab < n_full) begin
      if (exp_s[ab] < 4) begin
        n = ab + 1;
        exp_s[n++] = 6;
        exp_s[n++] = 7;
      end else if (exp_s[ab] == 4 || exp_s[ab] == 5) begin
        for (int k = 0; k < n_full; k++) if (exp_s[k] == 5) n = k + 1;
        exp_s[n++] = 6;
        exp_s[n++] = 7;
      end
    end
    pt2c = 0;
    pt3c = 0;
    ok_seq = 1'b1;
    op_cls = cls[2:0];
    for (int t = 0; t < n; t++) begin
      idx = decode(state_oh);
      if (ok_seq) begin
        chk(idx == exp_s[t], (data_c ? "R4/R5/R6" : (cls == 2 ? "R8" : (cls == 1 ? "R7" : "R3"))), idx, exp_s[t]);
        if (idx != exp_s[t]) ok_seq = 1'b0;
      end
      if (ab >= 0 && exp_s[t] != idx) ok_seq = 1'b0;
      bus_grant = (idx == 1) && (pt2c >= g);
      ssyn_in   = data_c && (idx == 2) && (pt3c >= d);
      abort_req = (t == ab);
      nx_ctl    = (nx != 0);
      #1;
      chk($countones(state_oh) == 1 && mclk == (idx < 4 && idx >= 0), "R2", int'(mclk), int'(idx < 4));
      chk(lat_add == (idx == 2 && addr_c && t != ab), "R7/R12 lat_add", int'(lat_add), int'(idx == 2 && addr_c && t != ab));
      chk(din_stb == (idx == 3 && t != ab), "R6/R12 din_stb", int'(din_stb), int'(idx == 3 && t != ab));
      chk(reloc_stb == (idx == 6 && cls == 2 && !(ab >= 0 && ab <= 2)), "R8/R12 reloc_stb",
          int'(reloc_stb), int'(idx == 6 && cls == 2 && !(ab >= 0 && ab <= 2)));
      if (idx == 1) pt2c++;
      if (idx == 2) pt3c++;
      @(negedge clk);
    end
    bus_grant = 1'b0;
    ssyn_in = 1'b0;
    abort_req = 1'b0;
    nx_ctl = 1'b0;
    chk(decode(state_oh) == 0, (ab >= 0) ? "R9/R11 return to P1" : "R10 return to P1", decode(state_oh), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: values held during reset
    chk(state_oh == 8'h01 && mclk && !lat_add && !din_stb && !reloc_stb, "R1", int'(state_oh), 1);
    rst_n = 1'b1;
    #1;
    chk(state_oh == 8'h01 && mclk, "R1 after release", int'(state_oh), 1);
    #1;
    // sweep: classes 0..7 (5..7 behave as plain, R3), grant delay R4, sync delay R5, nx R10
    for (int c = 0; c < 8; c++)
      for (int g = 0; g < 4; g++)
        for (int d = 0; d < 4; d++)
          for (int x = 0; x < 2; x++) begin
            if ((c == 3 || c == 4) || (g == 0 && d == 0)) run_cycle(c, g, d, -1, x);
          end
    // abort placed in every tick of each class: R9, and R11 in B3/B4
    for (int c = 0; c < 5; c++)
      for (int x = 0; x < 2; x++)
        for (int a = 0; a < 16; a++)
          run_cycle(c, 1, 1, a, x);
    // a plain cycle after relocation must not keep a pending B3 (R3)
    run_cycle(2, 0, 0, -1, 0);
    run_cycle(0, 0, 0, -1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule